// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

A 32-bit processor core that fetches, decodes, executes and retires one instruction on every clock edge. Nine instructions are supported: word load and store, register add, subtract, and, or and signed set-less-than, branch-if-equal and an unconditional jump. Every datapath resource is dedicated and none is shared. These resources are the program counter with its own +4 incrementer, a separate branch-target adder, a 32-entry by 32-bit register file with two read ports and one write port, a sign extender, a main decoder with a two-bit operation class, an ALU controller and the ALU. Multiplexers choose the destination register, the second ALU operand, the write-back value and the next program counter.

Instruction and data storage are internal word arrays. Both arrays are filled through one load port while the core is held in reset. The core exposes the current program counter, its register write-back bus and its data store bus so that its progress can be observed.

Top module: `sc_cpu`

## Requirements
- R1: While rst_ni is low, pc_o reads 0 and every register reads 0. The first instruction executes from address 0 after release.
- R2: The program counter is loaded on every rising clock edge, with no enable. For load, store and register-to-register instructions it advances by 4.
- R3: Branch-if-equal (opcode 000100) subtracts rt from rs. When the result is zero, the next PC is PC+4 plus the sign-extended 16-bit field [15:0] shifted left by 2; otherwise it is PC+4. Both forward and backward offsets are supported.
- R4: Jump (opcode 000010) sets the next PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R5: A register changes only on a clock edge, and only the one register addressed when rf_we_o is 1. The destination is instr[15:11] for register-to-register instructions (opcode 000000) and instr[20:16] for loads.
- R6: Register 0 always reads as 0. A write aimed at it has no effect on later reads.
- R7: With opcode 000000, funct [5:0] selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed set-less-than (result 1 or 0). Operands are rs [25:21] and rt [20:16].
- R8: A load (opcode 100011) or a store (opcode 101011) forms its byte address as rs plus the sign-extended 16-bit offset and indexes the data words with address bits [31:2]. A load returns the addressed word combinationally and writes it back. A store writes rt into that word on the clock edge.
- R9: Stores, branches and jumps drive rf_we_o low. Only stores drive dm_we_o high.
- R10: While ld_we_i is high, ld_data_i is written on the clock edge into word ld_addr_i of instruction storage (ld_dmem_i = 0) or of data storage (ld_dmem_i = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Load-port write strobe, used only while in reset |
| ld_dmem_i | input | 1 | Load-port target: 0 instruction words, 1 data words |
| ld_addr_i | input | LD_AW | Load-port word index |
| ld_data_i | input | 32 | Load-port word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register of the current instruction |
| rf_wdata_o | output | 32 | Write-back value of the current instruction |
| dm_we_o | output | 1 | Data store strobe of the current instruction |
| dm_addr_o | output | 32 | Data byte address computed by the ALU |
| dm_wdata_o | output | 32 | Data store value |

## Verification
The core can read a register in the same cycle in which it writes that register. The program includes an instruction that adds a register to itself and overwrites it (add r2,r2,r1), as well as a load that reads back a word stored by the instruction just before it. Both must see the value held before the edge and deliver the new value only to later instructions. A cycle-accurate behavioural model in the bench updates its state only after it has compared each cycle's outputs, so a write that takes effect at the wrong time shows up as a miscompare in the following cycle.

// File: rtl/sc_cpu_pkg.sv
`timescale 1ns/1ps
package sc_cpu_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_class_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic       dst_rd;
    logic       src_imm;
    logic       wb_mem;
    logic       reg_write;
    logic       mem_write;
    logic       branch;
    logic       jump;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_q[0] = '0;
    end else begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               regs_q[g] <= '0;
        else if (we_i && (waddr_i == AW'(g)))      regs_q[g] <= wdata_i;
      end
      // R5: unaddressed registers hold their value
      a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && (waddr_i == AW'(g))) |=> $stable(regs_q[g]));
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  a_r6_r0_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o == '0));
endmodule

// File: rtl/sc_ctrl.sv
`timescale 1ns/1ps
module sc_ctrl
  import sc_cpu_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o
);
  // main decoder
  always_comb begin
    ctrl_o = '0;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd    = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_class = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl_o.src_imm   = 1'b1;
        ctrl_o.wb_mem    = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      OP_SW: begin
        ctrl_o.src_imm   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch    = 1'b1;
        ctrl_o.alu_class = AOP_SUB;
      end
      OP_JMP:  ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end

  // ALU controller
  always_comb begin
    unique case (ctrl_o.alu_class)
      AOP_SUB: alu_fn_o = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct_i)
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: alu_fn_o = ALU_ADD;
        endcase
      end
      default: alu_fn_o = ALU_ADD;
    endcase
  end

  // R9: no write-back from store, branch or jump
  always_comb begin
    a_r9_no_wb: assert (!(ctrl_o.mem_write || ctrl_o.branch || ctrl_o.jump) || !ctrl_o.reg_write);
  end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_SLT: res_o = W'($signed(a_i) < $signed(b_i));
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);

  // R7: set-less-than yields 0 or 1
  always_comb begin
    a_r7_slt_bool: assert (fn_i != ALU_SLT || res_o[W-1:1] == '0);
  end
endmodule

// File: rtl/sc_cpu.sv
`timescale 1ns/1ps
module sc_cpu
  import sc_cpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int LD_AW = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic             ld_dmem_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [31:0]      ld_data_i,
  output logic [31:0]      pc_o,
  output logic             rf_we_o,
  output logic [4:0]       rf_waddr_o,
  output logic [31:0]      rf_wdata_o,
  output logic             dm_we_o,
  output logic [31:0]      dm_addr_o,
  output logic [31:0]      dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0] pc_q, pc_plus4, br_tgt, jmp_tgt, pc_nxt;
  logic [31:0] instr, imm_sx, rs_val, rt_val, alu_b, alu_res, dm_rdata;
  logic [31:0] imem_q [IMEM_WORDS];
  logic [31:0] dmem_q [DMEM_WORDS];
  logic [DAW-1:0] dm_idx;
  logic        alu_zero;
  ctrl_t       ctrl;
  alu_fn_e     alu_fn;

  // storage and load port
  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem_q[ld_addr_i[IAW-1:0]] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i)        dmem_q[ld_addr_i[DAW-1:0]] <= ld_data_i;
    else if (rst_ni && ctrl.mem_write) dmem_q[dm_idx] <= rt_val;
  end

  // fetch and next PC
  assign instr    = imem_q[pc_q[IAW+1:2]];
  assign pc_plus4 = pc_q + 32'd4;
  assign imm_sx   = {{16{instr[15]}}, instr[15:0]};
  assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                     pc_nxt = jmp_tgt;
    else if (ctrl.branch && alu_zero)  pc_nxt = br_tgt;
    else                               pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_nxt;
  end

  sc_ctrl u_ctrl (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl),
    .alu_fn_o (alu_fn)
  );

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl.reg_write),
    .waddr_i   (rf_waddr_o),
    .wdata_i   (rf_wdata_o),
    .raddr_a_i (instr[25:21]),
    .raddr_b_i (instr[20:16]),
    .rdata_a_o (rs_val),
    .rdata_b_o (rt_val)
  );

  assign alu_b = ctrl.src_imm ? imm_sx : rt_val;

  sc_alu #(.W(32)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  assign dm_idx   = alu_res[DAW+1:2];
  assign dm_rdata = dmem_q[dm_idx];

  assign pc_o       = pc_q;
  assign rf_we_o    = ctrl.reg_write;
  assign rf_waddr_o = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign rf_wdata_o = ctrl.wb_mem ? dm_rdata : alu_res;
  assign dm_we_o    = ctrl.mem_write;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_val;

  // one-cycle-after-reset qualifier for history checks
  logic chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= 1'b1;
  end

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q && $past(!ctrl.jump && !ctrl.branch) |-> pc_q == $past(pc_q) + 32'd4);

  a_r3_branch_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q && $past(ctrl.branch && alu_zero) |-> pc_q == $past(br_tgt));

  a_r4_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q && $past(ctrl.jump) |-> pc_q[27:0] == {$past(instr[25:0]), 2'b00});

  a_r8_store_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q && $past(ctrl.mem_write) |-> dmem_q[$past(dm_idx)] == $past(rt_val));
endmodule

// File: tb/sc_cpu_test.sv
`timescale 1ns/1ps
module sc_cpu_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_we, ld_dmem;
  logic [5:0]  ld_addr;
  logic [31:0] ld_data;
  logic [31:0] pc, rf_wdata, dm_addr, dm_wdata;
  logic        rf_we, dm_we;
  logic [4:0]  rf_waddr;

  always #4 clk = ~clk;

  sc_cpu uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_we_i(ld_we), .ld_dmem_i(ld_dmem), .ld_addr_i(ld_addr), .ld_data_i(ld_data),
    .pc_o(pc), .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .dm_we_o(dm_we), .dm_addr_o(dm_addr), .dm_wdata_o(dm_wdata)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] prog [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  string pc_tag;

  function automatic logic [31:0] r_ins(logic [5:0] fn, int rs, int rt, int rd);
    return {6'b000000, rs[4:0], rt[4:0], rd[4:0], 5'b00000, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s pc=%h actual=%h expected=%h", tag, m_pc, act, exp);
    end
  endtask

  // behavioural reference: compare this cycle, then commit
  task automatic ref_step();
    logic [31:0] ins, sx, a, b, r, addr, nxt;
    logic [5:0]  op, fn;
    int rs, rt, rd;
    chk(pc_tag, pc, m_pc);
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    sx = {{16{ins[15]}}, ins[15:0]};
    a = m_rf[rs]; b = m_rf[rt];
    addr = a + sx;
    nxt = m_pc + 4;
    pc_tag = "R2";
    case (op)
      6'b000000: begin
        case (fn)
          6'b100010: r = a - b;
          6'b100100: r = a & b;
          6'b100101: r = a | b;
          6'b101010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   r = a + b;
        endcase
        chk("R5 we", {31'b0, rf_we}, 32'd1);
        chk("R5 rd dest", {27'b0, rf_waddr}, rd);
        chk((rd == 0) ? "R6 r0 write" : "R7 alu", rf_wdata, r);
        chk("R9 no store", {31'b0, dm_we}, 32'd0);
        if (rd != 0) m_rf[rd] = r;
      end
      6'b100011: begin
        chk("R5 we", {31'b0, rf_we}, 32'd1);
        chk("R5 rt dest", {27'b0, rf_waddr}, rt);
        chk("R8/R10 load data", rf_wdata, m_dm[addr[7:2]]);
        chk("R9 no store", {31'b0, dm_we}, 32'd0);
        if (rt != 0) m_rf[rt] = m_dm[addr[7:2]];
      end
      6'b101011: begin
        chk("R9 store no wb", {31'b0, rf_we}, 32'd0);
        chk("R8 store strobe", {31'b0, dm_we}, 32'd1);
        chk("R8 store addr", dm_addr, addr);
        chk((rt == 0) ? "R6 r0 reads zero" : "R8 store data", dm_wdata, b);
        m_dm[addr[7:2]] = b;
      end
      6'b000100: begin
        chk("R9 branch no wb", {31'b0, rf_we}, 32'd0);
        chk("R9 branch no store", {31'b0, dm_we}, 32'd0);
        if (a == b) nxt = m_pc + 4 + {sx[29:0], 2'b00};
        pc_tag = "R3";
      end
      6'b000010: begin
        chk("R9 jump no wb", {31'b0, rf_we}, 32'd0);
        nxt = {nxt[31:28], ins[25:0], 2'b00};
        pc_tag = "R4";
      end
      default: ;
    endcase
    m_pc = nxt;
  endtask

  task automatic ld_word(bit sel, int idx, logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = sel; ld_addr = idx[5:0]; ld_data = d;
    @(posedge clk);
  endtask

  task automatic model_reset();
    m_pc = 0;
    pc_tag = "R1";
    for (int i = 0; i < 32; i++) m_rf[i] = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; ld_dmem = 1'b0; ld_addr = '0; ld_data = '0;
    for (int i = 0; i < 64; i++) prog[i] = '0;
    prog[0]  = i_ins(6'b100011, 0, 1, 0);        // lw r1,0(r0)
    prog[1]  = i_ins(6'b100011, 0, 2, 4);        // lw r2,4(r0)
    prog[2]  = i_ins(6'b100011, 0, 3, 8);        // lw r3,8(r0)
    prog[3]  = r_ins(6'b100000, 1, 2, 4);        // add r4
    prog[4]  = r_ins(6'b100010, 1, 2, 5);        // sub r5 (negative)
    prog[5]  = r_ins(6'b100100, 2, 3, 6);        // and
    prog[6]  = r_ins(6'b100101, 1, 3, 7);        // or
    prog[7]  = r_ins(6'b101010, 3, 1, 8);        // slt negative<positive
    prog[8]  = r_ins(6'b101010, 1, 3, 9);        // slt positive<negative
    prog[9]  = r_ins(6'b100000, 1, 2, 0);        // write to r0
    prog[10] = i_ins(6'b101011, 0, 0, 16);       // sw r0
    prog[11] = i_ins(6'b101011, 0, 4, 20);       // sw r4
    prog[12] = i_ins(6'b100011, 0, 10, 20);      // lw r10 readback
    prog[13] = i_ins(6'b000100, 1, 2, 5);        // beq not taken
    prog[14] = i_ins(6'b000100, 4, 10, 2);       // beq taken -> 17
    prog[15] = r_ins(6'b100000, 1, 1, 11);
    prog[16] = r_ins(6'b100000, 1, 1, 11);
    prog[17] = i_ins(6'b100011, 4, 12, -4);      // negative offset
    prog[18] = r_ins(6'b100000, 2, 1, 2);        // read and write r2
    prog[19] = i_ins(6'b000100, 0, 0, 1);        // beq -> 21
    prog[20] = r_ins(6'b100010, 1, 1, 11);
    prog[21] = {6'b000010, 26'd23};              // j 23
    prog[22] = r_ins(6'b100010, 1, 1, 11);
    prog[23] = i_ins(6'b000100, 1, 1, -24);      // backward -> 0
    m_dm[0] = 32'd5; m_dm[1] = 32'd7; m_dm[2] = 32'hFFFF_FFF0; m_dm[3] = 32'h1234_5678;
    for (int i = 4; i < 64; i++) m_dm[i] = '0;

    for (int i = 0; i < 64; i++) ld_word(1'b0, i, prog[i]);
    for (int i = 0; i < 64; i++) ld_word(1'b1, i, m_dm[i]);
    @(negedge clk);
    ld_we = 1'b0;
    model_reset();
    #1 chk("R1 reset pc", pc, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    #1 ref_step();
    repeat (120) begin
      @(negedge clk);
      #1 ref_step();
    end

    // reset mid-run: registers clear, data words persist
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    #1 chk("R1 reset pc", pc, 32'd0);
    @(negedge clk);
    chk("R1 reset pc held", pc, 32'd0);
    rst_n = 1'b1;
    #1 ref_step();
    repeat (60) begin
      @(negedge clk);
      #1 ref_step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule